// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block takes one block-transfer instruction word and turns it into a serial stream of micro-ops for a pipeline back end. The instruction holds a 16-bit register list in its low half, a base register index, a condition field, and five mode flags: pre/post, up/down, a privileged-transfer flag, writeback and load/store. After one word is accepted, the block sends one micro-op per cycle over a valid/ready handshake.

The first micro-op is a copy of the base register. Next comes one load or store micro-op for each register selected in the list, lowest index first, each with its byte offset. When writeback is requested, a final immediate add or subtract moves the base by four bytes per transferred register. The final micro-op of every sequence carries a last flag. A mode combination outside the supported set produces a one-cycle error pulse and emits nothing.

Top module: `lsm_uop_seq`

## Requirements
- R1: An accepted supported word produces exactly popcount(word[15:0]) + 1 + W micro-ops. The mode field is word[24:20] ordered {P,U,S,W,L}, with W at word[21].
- R2: The first micro-op has kind 0 (copy). Its word equals the instruction's bits 31:16 followed by sixteen zero bits.
- R3: Transfer micro-ops (kind 1) name the selected registers in ascending index order, each one exactly once.
- R4: With P=0, the first transfer offset is 4*count-4 when U=0 and 0 when U=1.
- R5: With P=1, the first transfer offset is 4*count when U=0 and 4 when U=1. Every transfer micro-op drives uop_down equal to the inverse of U and uop_load equal to L (word[20]).
- R6: Each transfer after the first has an offset 4 above the previous one when U=1 and 4 below it when U=0.
- R7: With W=1, the final micro-op is kind 2 (add) when U=1 and kind 3 (subtract) when U=0. Its word is {cond,28'h0} | 32'h02400000 | Rn<<16 | Rn<<12 | 4*count, where cond is word[31:28] and Rn is word[19:16].
- R8: uop_last is high on the final micro-op of a sequence and low on all others, including when the register list is empty.
- R9: Only mode values 0x01, 0x03, 0x08, 0x09, 0x0B, 0x11, 0x12, 0x18 and 0x19 are supported. Accepting any other value raises mode_err for exactly one cycle, and no micro-op follows.
- R10: in_ready is high only when no sequence is in progress. While uop_valid is high and uop_ready is low, every micro-op output holds its value.
- R11: After reset, uop_valid and mode_err are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Sequencer idle and able to take a word |
| in_word | input | 32 | Block-transfer instruction word |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_kind | output | 2 | 0 copy, 1 transfer, 2 add update, 3 subtract update |
| uop_word | output | 32 | Encoded word for copy and update micro-ops, zero for transfers |
| uop_reg | output | 4 | Register index of a transfer |
| uop_offset | output | 7 | Byte offset of a transfer |
| uop_load | output | 1 | Transfer is a load |
| uop_down | output | 1 | Transfer uses subtracted addressing |
| uop_last | output | 1 | Final micro-op of the sequence |
| mode_err | output | 1 | One-cycle pulse after an unsupported word is accepted |

## Verification
The hardest case to reach is a stalled consumer on the step where the register list empties. At that point the last flag and the choice between the update micro-op and returning to idle both depend on the list after the pending register is cleared, and that result has to hold steady through the stall. To reach it, the stimulus applies an irregular ready pattern across sequences whose lists have one, several and all sixteen bits set, with and without writeback. A scoreboard compares each accepted micro-op against an independently built expectation, and the bench also checks that held outputs stay unchanged.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    K_COPY = 2'd0,
    K_XFER = 2'd1,
    K_ADD  = 2'd2,
    K_SUB  = 2'd3
  } uop_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_COPY = 2'd1,
    S_XFER = 2'd2,
    S_UPD  = 2'd3
  } seq_state_e;

  localparam int MODE_LSB = 20;
  localparam int RN_LSB   = 16;
  localparam int UPD_OP   = 32'h0240_0000;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CNT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/lsm_pick_lowest.sv
module lsm_pick_lowest #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     req,
  output logic [W-1:0]     grant,
  output logic [IDX_W-1:0] idx
);
  logic [W:0] clear;

  assign clear[0] = 1'b1;
  for (genvar g = 0; g < W; g++) begin : g_chain
    assign grant[g]   = req[g] & clear[g];
    assign clear[g+1] = clear[g] & ~req[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end

  // R3: one grant at most, and only when something is requested
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((req != '0) == (grant != '0)));
endmodule

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode #(
  parameter int CNT_W = 5,
  parameter int OFS_W = 7
) (
  input  logic [4:0]       mode,
  input  logic [CNT_W-1:0] cnt,
  output logic             ok,
  output logic [OFS_W-1:0] start_ofs
);
  logic [OFS_W-1:0] span;

  assign span = OFS_W'(cnt) << 2;

  always_comb begin
    unique case (mode)
      5'h01, 5'h03, 5'h08, 5'h09, 5'h0B,
      5'h11, 5'h12, 5'h18, 5'h19: ok = 1'b1;
      default:                    ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (mode[4:3])
      2'b00:   start_ofs = span - OFS_W'(4);
      2'b01:   start_ofs = '0;
      2'b10:   start_ofs = span;
      default: start_ofs = OFS_W'(4);
    endcase
  end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
  import lsm_pkg::*;
#(
  parameter int REGS  = 16,
  parameter int IW    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        uop_valid,
  input  logic        uop_ready,
  output logic [1:0]  uop_kind,
  output logic [31:0] uop_word,
  output logic [3:0]  uop_reg,
  output logic [6:0]  uop_offset,
  output logic        uop_load,
  output logic        uop_down,
  output logic        uop_last,
  output logic        mode_err
);
  localparam int CNT_W = $clog2(REGS + 1);
  localparam int IDX_W = $clog2(REGS);
  localparam int OFS_W = $clog2(REGS * 4 + 1);

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  seq_state_e       st_q, st_d;
  logic [IW-1:0]    word_q, word_d;
  logic [REGS-1:0]  rem_q, rem_d;
  logic [OFS_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;

  logic [CNT_W-1:0] in_cnt;
  logic             in_ok;
  logic [OFS_W-1:0] in_start;
  logic [REGS-1:0]  grant;
  logic [IDX_W-1:0] pick_idx;
  logic [REGS-1:0]  rem_after;
  logic             accept, fire;
  logic             up_q, wb_q, ld_q;
  logic [3:0]       rn_q;

  lsm_popcount #(.W(REGS), .CNT_W(CNT_W)) u_cnt (
    .vec (in_word[REGS-1:0]),
    .cnt (in_cnt)
  );

  lsm_mode_decode #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_dec (
    .mode      (in_word[MODE_LSB+4:MODE_LSB]),
    .cnt       (in_cnt),
    .ok        (in_ok),
    .start_ofs (in_start)
  );

  lsm_pick_lowest #(.W(REGS), .IDX_W(IDX_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_q_n),
    .req   (rem_q),
    .grant (grant),
    .idx   (pick_idx)
  );

  assign rem_after = rem_q & ~grant;
  assign up_q      = word_q[MODE_LSB+3];
  assign wb_q      = word_q[MODE_LSB+1];
  assign ld_q      = word_q[MODE_LSB];
  assign rn_q      = word_q[RN_LSB+3:RN_LSB];

  assign in_ready  = (st_q == S_IDLE) && rst_q_n;
  assign accept    = in_valid && in_ready;
  assign uop_valid = (st_q != S_IDLE);
  assign fire      = uop_valid && uop_ready;
  assign mode_err  = err_q;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    word_d = word_q;
    rem_d  = rem_q;
    off_d  = off_q;
    cnt_d  = cnt_q;
    err_d  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (accept) begin
          if (in_ok) begin
            st_d   = S_COPY;
            word_d = in_word;
            rem_d  = in_word[REGS-1:0];
            off_d  = in_start;
            cnt_d  = in_cnt;
          end else begin
            err_d  = 1'b1;
          end
        end
      end
      S_COPY: begin
        if (fire) begin
          if (rem_q != '0) st_d = S_XFER;
          else if (wb_q)   st_d = S_UPD;
          else             st_d = S_IDLE;
        end
      end
      S_XFER: begin
        if (fire) begin
          rem_d = rem_after;
          off_d = up_q ? off_q + OFS_W'(4) : off_q - OFS_W'(4);
          if (rem_after == '0) st_d = wb_q ? S_UPD : S_IDLE;
        end
      end
      default: begin
        if (fire) st_d = S_IDLE;
      end
    endcase
  end

  // state registers with written-out enables
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q  <= S_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      word_q <= '0;
      rem_q  <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
    end else if (accept || fire) begin
      word_q <= word_d;
      rem_q  <= rem_d;
      off_q  <= off_d;
      cnt_q  <= cnt_d;
    end
  end

  // output decode
  always_comb begin
    uop_kind   = K_COPY;
    uop_word   = '0;
    uop_reg    = '0;
    uop_offset = '0;
    uop_load   = 1'b0;
    uop_down   = 1'b0;
    uop_last   = 1'b0;
    unique case (st_q)
      S_COPY: begin
        uop_kind = K_COPY;
        uop_word = {word_q[31:16], 16'h0000};
        uop_last = (rem_q == '0) && !wb_q;
      end
      S_XFER: begin
        uop_kind   = K_XFER;
        uop_reg    = 4'(pick_idx);
        uop_offset = 7'(off_q);
        uop_load   = ld_q;
        uop_down   = !up_q;
        uop_last   = (rem_after == '0) && !wb_q;
      end
      S_UPD: begin
        uop_kind = up_q ? K_ADD : K_SUB;
        uop_word = {word_q[31:28], 28'h0} | 32'(UPD_OP)
                 | (32'(rn_q) << 16) | (32'(rn_q) << 12)
                 | (32'(cnt_q) << 2);
        uop_last = 1'b1;
      end
      default: ;
    endcase
  end

  // R10: held micro-op stays put under backpressure
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_kind) && $stable(uop_word)
      && $stable(uop_reg) && $stable(uop_offset) && $stable(uop_last)));

  // R10: no new word taken mid-sequence
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    uop_valid |-> !in_ready);

  // R8: a sequence ends after its last micro-op is taken
  p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fire && uop_last) |=> !uop_valid);

  // R8: a non-last micro-op taken is followed by another
  p_more_follows_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fire && !uop_last) |=> uop_valid);

  // R2: every sequence begins with the copy
  p_copy_first_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (accept && !mode_err && in_ok) |=> (uop_valid && uop_kind == K_COPY));

  // R9: error pulse is one cycle long and emits nothing
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_err |-> (!uop_valid && in_ready));

  // R6: consecutive transfers step by four
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fire && uop_kind == K_XFER && !uop_last && !($past(uop_kind) == K_XFER && 1'b0))
      ##1 (uop_valid && uop_kind == K_XFER)
      |-> (uop_down ? (uop_offset == $past(uop_offset) - 7'd4)
                    : (uop_offset == $past(uop_offset) + 7'd4)));

  // R3: register indices strictly rise through a sequence
  p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fire && uop_kind == K_XFER) ##1 (uop_valid && uop_kind == K_XFER)
      |-> (uop_reg > $past(uop_reg)));
endmodule

// File: tb/sim_lsm_uop_seq.sv
module sim_lsm_uop_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        uop_valid;
  logic        uop_ready = 1'b1;
  logic [1:0]  uop_kind;
  logic [31:0] uop_word;
  logic [3:0]  uop_reg;
  logic [6:0]  uop_offset;
  logic        uop_load, uop_down, uop_last, mode_err;

  always #2.5 clk = ~clk;

  lsm_uop_seq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_kind(uop_kind), .uop_word(uop_word), .uop_reg(uop_reg),
    .uop_offset(uop_offset), .uop_load(uop_load), .uop_down(uop_down),
    .uop_last(uop_last), .mode_err(mode_err)
  );

  int errors = 0;
  int checks = 0;
  int popped = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  bit live = 1'b0;
  bit held = 1'b0;
  logic [47:0] prev_item;
  logic [47:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] mk(input logic [3:0] cond, input logic [4:0] mode,
                                     input logic [3:0] rn, input logic [15:0] list);
    return {cond, 3'b100, mode, rn, list};
  endfunction

  function automatic logic [47:0] item(input logic [1:0] k, input logic [31:0] w,
      input logic [3:0] r, input logic [6:0] o, input logic ld, input logic dn, input logic la);
    return {k, w, r, o, ld, dn, la};
  endfunction

  // driver: build the expected stream from the requirements, then offer the word
  task automatic send(input logic [31:0] w);
    logic [4:0] mode;
    bit sup, p, u, wb, ld;
    int cnt, ofs, n, expn, k;
    mode = w[24:20];
    p = mode[4]; u = mode[3]; wb = mode[1]; ld = mode[0];
    sup = (mode == 5'h01 || mode == 5'h03 || mode == 5'h08 || mode == 5'h09 ||
           mode == 5'h0B || mode == 5'h11 || mode == 5'h12 || mode == 5'h18 || mode == 5'h19);
    cnt = $countones(w[15:0]);
    expn = 0;
    if (sup) begin
      expn = cnt + 1 + int'(wb);
      exp_q.push_back(item(2'd0, {w[31:16], 16'h0}, 4'd0, 7'd0, 1'b0, 1'b0, expn == 1));
      tag_q.push_back("R2");
      if (!p) ofs = u ? 0 : cnt * 4 - 4;
      else    ofs = u ? 4 : cnt * 4;
      n = 0;
      for (int i = 0; i < 16; i++) begin
        if (w[i]) begin
          n++;
          exp_q.push_back(item(2'd1, 32'd0, 4'(i), 7'(ofs), ld, !u, (n == cnt) && !wb));
          tag_q.push_back(n == 1 ? (p ? "R5" : "R4") : "R6");
          ofs = u ? ofs + 4 : ofs - 4;
        end
      end
      if (wb) begin
        exp_q.push_back(item(u ? 2'd2 : 2'd3,
          {w[31:28], 28'h0} | 32'h0240_0000 | (32'(w[19:16]) << 16) |
          (32'(w[19:16]) << 12) | 32'(cnt * 4), 4'd0, 7'd0, 1'b0, 1'b0, 1'b1));
        tag_q.push_back("R7");
      end
    end
    popped = 0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_word = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (!sup) begin
      chk(mode_err == 1'b1, "R9 err raised", 64'(mode_err), 64'd1);
      @(negedge clk);
      chk(mode_err == 1'b0, "R9 err one cycle", 64'(mode_err), 64'd0);
      for (int c = 0; c < 4; c++) @(negedge clk);
      chk(popped == 0, "R9 no uops", 64'(popped), 64'd0);
    end else begin
      k = 0;
      while ((exp_q.size() != 0 || uop_valid) && k < 2000) begin
        @(negedge clk);
        k++;
      end
      chk(popped == expn, "R1 uop count", 64'(popped), 64'(expn));
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [47:0] act, exp;
    string tag;
    bit rdy;
    cyc++;
    rdy = bp_on ? ((cyc % 5) != 2 && (cyc % 7) != 4) : 1'b1;
    uop_ready = rdy;
    if (live && uop_valid) begin
      act = {uop_kind, uop_word, uop_reg, uop_offset, uop_load, uop_down, uop_last};
      chk(!in_ready, "R10 in_ready low while busy", 64'(in_ready), 64'd0);
      if (held) chk(act == prev_item, "R10 held outputs", 64'(act), 64'(prev_item));
      if (rdy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected uop", 64'(act), 64'd0);
        end else begin
          exp = exp_q.pop_front();
          tag = tag_q.pop_front();
          popped++;
          chk(act[47:14] == exp[47:14], {tag, " kind/word"}, 64'(act[47:14]), 64'(exp[47:14]));
          chk(act[13:10] == exp[13:10], "R3 register order", 64'(act[13:10]), 64'(exp[13:10]));
          chk(act[9:1] == exp[9:1], {tag, " offset/load/down"}, 64'(act[9:1]), 64'(exp[9:1]));
          chk(act[0] == exp[0], "R8 last flag", 64'(act[0]), 64'(exp[0]));
        end
      end
      held = !rdy;
      prev_item = act;
    end else begin
      held = 1'b0;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(uop_valid == 1'b0, "R11 no valid in reset", 64'(uop_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R11 ready after reset", 64'(in_ready), 64'd1);
    chk(uop_valid == 1'b0, "R11 valid low after reset", 64'(uop_valid), 64'd0);
    chk(mode_err == 1'b0, "R11 err low after reset", 64'(mode_err), 64'd0);
    live = 1'b1;

    // every supported mode, free-flowing consumer
    send(mk(4'hE, 5'h0B, 4'd3, 16'h00A5));
    send(mk(4'h1, 5'h09, 4'd7, 16'h8001));
    send(mk(4'hE, 5'h08, 4'd13, 16'h0F0F));
    send(mk(4'h2, 5'h01, 4'd4, 16'h0036));
    send(mk(4'hE, 5'h03, 4'd9, 16'h1240));
    send(mk(4'h0, 5'h11, 4'd2, 16'h000F));
    send(mk(4'hE, 5'h12, 4'd13, 16'h8000));
    send(mk(4'hA, 5'h18, 4'd5, 16'h0300));
    send(mk(4'hE, 5'h19, 4'd11, 16'h4081));
    // empty lists
    send(mk(4'hE, 5'h01, 4'd1, 16'h0000));
    send(mk(4'h7, 5'h03, 4'd6, 16'h0000));
    send(mk(4'hE, 5'h12, 4'd15, 16'h0000));
    // unsupported modes
    send(mk(4'hE, 5'h00, 4'd1, 16'h00FF));
    send(mk(4'hE, 5'h1F, 4'd1, 16'h0001));
    send(mk(4'hE, 5'h0A, 4'd1, 16'h0010));
    // backpressure
    bp_on = 1'b1;
    send(mk(4'hE, 5'h0B, 4'd0, 16'hFFFF));
    send(mk(4'h3, 5'h12, 4'd8, 16'hFFFF));
    send(mk(4'hE, 5'h03, 4'd2, 16'h0001));
    send(mk(4'hE, 5'h18, 4'd12, 16'hA5A5));
    send(mk(4'hE, 5'h11, 4'd14, 16'h8421));
    send(mk(4'hE, 5'h09, 4'd3, 16'h0000));
    send(mk(4'hE, 5'h1B, 4'd3, 16'h0002));
    bp_on = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule